// File: doc/BRIEF.md
# Channel Condition Flag Registers

This block keeps the condition flags for one output channel of a programmable supply. Seven hardware condition inputs, plus a coupled-parameter flag that the block keeps itself, form a live status word. Three more 8-bit registers sit around that word:

- an accumulator that remembers every condition entered since it was last read;
- a user-owned enable mask;
- a fault register that captures unmasked conditions and holds them after they go away.

A service-request output signals a captured fault when that feature is turned on.

Software-side logic reads the four registers through a valid/ready request stream and gets the data back on a valid/ready response stream. A request is accepted when `req_valid_i && req_ready_o`. Its side effects (reloading the accumulator, clearing the fault register) happen at that clock edge, and the data appears on the response one cycle later. The response stage holds a single entry. While a response is waiting with `resp_ready_i` low, `req_ready_o` stays low, so no new request is taken and nothing changes state. The mask and the service-request enable are written through a plain write strobe.

Top module: `chan_flag_regs`

## Requirements
- R1: Status bits 6..0 follow `cond_i` one cycle later. The bit meanings are: bit 0 constant voltage, bit 1 positive constant current, bit 2 negative current limit, bit 3 over-voltage trip, bit 4 over-temperature trip, bit 5 unregulated, bit 6 over-current trip. Bit 7 is the coupled-parameter flag.
- R2: No write on the write strobe changes the status word; `wr_sel_i`=0 targets the mask and `wr_sel_i`=1 targets the request enable (`wr_data_i[0]`).
- R3: The accumulator ORs in every status bit that becomes active, so it always contains the present status.
- R4: An accepted accumulator read returns the accumulator and reloads it with the status of the following cycle, including a condition that arrives in the same cycle as the read. For example, an earlier over-voltage with constant voltage active now reads as 9.
- R5: The mask changes only on a mask write and keeps its value otherwise.
- R6: A status bit that is set while its mask bit is set is captured in the fault register and stays set after the condition ends.
- R7: An accepted fault read returns the fault register and clears it. A condition that is still active and unmasked is captured again on the following cycle.
- R8: `srq_o` is high exactly when the request enable is set and at least one fault bit is set.
- R9: The coupled flag sets on `cp_event_i`. It clears when `prog_wr_i` is high with `prog_chg_i` low. If both happen in the same cycle, set wins.
- R10: After reset all four registers read zero, the request enable is off, `srq_o` is low, `resp_valid_o` is low and `req_ready_o` is high.
- R11: Request select codes are 0 status, 1 accumulator, 2 mask and 3 fault; the response is valid in the cycle after acceptance.
- R12: While `resp_valid_o` is high and `resp_ready_i` is low, the response data holds steady and `req_ready_o` is low, so a pending request has no side effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cond_i | input | 7 | Hardware condition levels, bits 6..0 |
| cp_event_i | input | 1 | Range switch or power-limit event pulse |
| prog_wr_i | input | 1 | A voltage, current or range value was written |
| prog_chg_i | input | 1 | That write caused another setting to change |
| wr_en_i | input | 1 | Write strobe |
| wr_sel_i | input | 1 | Write target: 0 mask, 1 request enable |
| wr_data_i | input | 8 | Write data |
| req_valid_i | input | 1 | Read request valid |
| req_ready_o | output | 1 | Read request ready |
| req_sel_i | input | 2 | Register select for the request |
| resp_valid_o | output | 1 | Read response valid |
| resp_ready_i | input | 1 | Read response ready |
| resp_data_o | output | 8 | Read response data |
| srq_o | output | 1 | Service request |

## Verification
The bench builds the block with its default parameters: an 8-bit flag word and a 2-bit select. With these values the coupled flag sits in bit 7 and all four select codes can be reached. The scoreboard can therefore check the over-voltage plus constant-voltage reading of 9 and the coupled flag's set-over-clear priority directly. Back-to-back fault reads with a condition still held expose the one-cycle gap before the fault is captured again. A stalled response lets the bench confirm that a waiting request neither reloads nor clears anything.

// File: rtl/cfr_pkg.sv
package cfr_pkg;
  localparam int FLAG_W = 8;
  localparam int SEL_W  = 2;
  localparam int CP_BIT = FLAG_W - 1;
  localparam int HW_W   = FLAG_W - 1;

  typedef enum logic [SEL_W-1:0] {
    SEL_STATUS = 2'd0,
    SEL_ACCUM  = 2'd1,
    SEL_MASK   = 2'd2,
    SEL_FAULT  = 2'd3
  } rd_sel_e;
endpackage

// File: rtl/cfr_coupled.sv
module cfr_coupled (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic prog_wr_i,
  input  logic prog_chg_i,
  output logic flag_d_o,
  output logic flag_q_o
);
  // set has priority over a quiet programming write
  always_comb begin
    flag_d_o = flag_q_o;
    if (set_i)
      flag_d_o = 1'b1;
    else if (prog_wr_i && !prog_chg_i)
      flag_d_o = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flag_q_o <= 1'b0;
    else        flag_q_o <= flag_d_o;
  end
endmodule

// File: rtl/cfr_sticky.sv
module cfr_sticky #(
  parameter int W      = 8,
  parameter bit RELOAD = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic         clr_i,
  input  logic [W-1:0] reload_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic clr_val;
    if (RELOAD) begin : g_rl
      assign clr_val = reload_i[b];
    end else begin : g_zero
      assign clr_val = 1'b0;
    end

    always_ff @(posedge clk) begin
      if (!rst_n)        q_o[b] <= 1'b0;
      else if (clr_i)    q_o[b] <= clr_val;
      else if (set_i[b]) q_o[b] <= 1'b1;
    end
  end
endmodule

// File: rtl/cfr_rdport.sv
module cfr_rdport
  import cfr_pkg::*;
#(
  parameter int W = FLAG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [SEL_W-1:0] req_sel_i,
  input  logic [W-1:0]     stat_i,
  input  logic [W-1:0]     acc_i,
  input  logic [W-1:0]     mask_i,
  input  logic [W-1:0]     fault_i,
  output logic             acc_rd_o,
  output logic             fault_rd_o,
  output logic             resp_valid_o,
  input  logic             resp_ready_i,
  output logic [W-1:0]     resp_data_o
);
  logic         fire;
  logic [W-1:0] sel_val;

  assign req_ready_o = !resp_valid_o || resp_ready_i;
  assign fire        = req_valid_i && req_ready_o;
  assign acc_rd_o    = fire && (rd_sel_e'(req_sel_i) == SEL_ACCUM);
  assign fault_rd_o  = fire && (rd_sel_e'(req_sel_i) == SEL_FAULT);

  always_comb begin
    unique case (rd_sel_e'(req_sel_i))
      SEL_STATUS: sel_val = stat_i;
      SEL_ACCUM:  sel_val = acc_i;
      SEL_MASK:   sel_val = mask_i;
      SEL_FAULT:  sel_val = fault_i;
      default:    sel_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid_o <= 1'b0;
      resp_data_o  <= '0;
    end else if (fire) begin
      resp_valid_o <= 1'b1;
      resp_data_o  <= sel_val;
    end else if (resp_ready_i) begin
      resp_valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/chan_flag_regs.sv
module chan_flag_regs
  import cfr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HW_W-1:0]   cond_i,
  input  logic              cp_event_i,
  input  logic              prog_wr_i,
  input  logic              prog_chg_i,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [FLAG_W-1:0] wr_data_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [SEL_W-1:0]  req_sel_i,
  output logic              resp_valid_o,
  input  logic              resp_ready_i,
  output logic [FLAG_W-1:0] resp_data_o,
  output logic              srq_o
);
  logic              cp_d, cp_q;
  logic [FLAG_W-1:0] stat_d, stat_q;
  logic [FLAG_W-1:0] acc_q, mask_q, fault_q;
  logic              srq_en_q;
  logic              acc_rd, fault_rd;

  cfr_coupled u_cp (
    .clk(clk), .rst_n(rst_n), .set_i(cp_event_i),
    .prog_wr_i(prog_wr_i), .prog_chg_i(prog_chg_i),
    .flag_d_o(cp_d), .flag_q_o(cp_q)
  );

  assign stat_d = {cp_d, cond_i};

  always_ff @(posedge clk) begin
    if (!rst_n) stat_q[HW_W-1:0] <= '0;
    else        stat_q[HW_W-1:0] <= cond_i;
  end
  assign stat_q[CP_BIT] = cp_q;

  // accumulator: gathers next status, reloads with it on read
  cfr_sticky #(.W(FLAG_W), .RELOAD(1'b1)) u_acc (
    .clk(clk), .rst_n(rst_n), .set_i(stat_d), .clr_i(acc_rd),
    .reload_i(stat_d), .q_o(acc_q)
  );

  // fault: captures masked live status, zeroed on read
  cfr_sticky #(.W(FLAG_W), .RELOAD(1'b0)) u_fault (
    .clk(clk), .rst_n(rst_n), .set_i(stat_q & mask_q), .clr_i(fault_rd),
    .reload_i('0), .q_o(fault_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q   <= '0;
      srq_en_q <= 1'b0;
    end else if (wr_en_i) begin
      if (!wr_sel_i) mask_q   <= wr_data_i;
      else           srq_en_q <= wr_data_i[0];
    end
  end

  assign srq_o = srq_en_q && (|fault_q);

  cfr_rdport #(.W(FLAG_W)) u_rd (
    .clk(clk), .rst_n(rst_n),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o), .req_sel_i(req_sel_i),
    .stat_i(stat_q), .acc_i(acc_q), .mask_i(mask_q), .fault_i(fault_q),
    .acc_rd_o(acc_rd), .fault_rd_o(fault_rd),
    .resp_valid_o(resp_valid_o), .resp_ready_i(resp_ready_i),
    .resp_data_o(resp_data_o)
  );
endmodule

// File: rtl/cfr_checker.sv
module cfr_checker
  import cfr_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [HW_W-1:0]   cond_i,
  input logic              cp_event_i,
  input logic              prog_wr_i,
  input logic              prog_chg_i,
  input logic              wr_en_i,
  input logic              wr_sel_i,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic [SEL_W-1:0]  req_sel_i,
  input logic              resp_valid_o,
  input logic              resp_ready_i,
  input logic [FLAG_W-1:0] resp_data_o,
  input logic              srq_o,
  input logic [FLAG_W-1:0] stat_q,
  input logic [FLAG_W-1:0] acc_q,
  input logic [FLAG_W-1:0] mask_q,
  input logic [FLAG_W-1:0] fault_q,
  input logic              srq_en_q
);
  logic fault_fire;
  assign fault_fire = req_valid_i && req_ready_o && (req_sel_i == SEL_FAULT);

  AST_STATUS_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> stat_q[HW_W-1:0] == $past(cond_i)); // R1

  AST_NO_STATUS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(wr_en_i) |-> stat_q[HW_W-1:0] == $past(cond_i)); // R2

  AST_ACC_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_q & stat_q) == stat_q); // R3

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !($past(wr_en_i) && !$past(wr_sel_i)) |-> $stable(mask_q)); // R5

  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$past(fault_fire) |-> (fault_q & $past(fault_q)) == $past(fault_q)); // R6

  AST_FAULT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    fault_fire |=> fault_q == '0); // R7

  AST_SRQ_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    srq_o == (srq_en_q && fault_q != '0)); // R8

  AST_CP_SET: assert property (@(posedge clk) disable iff (!rst_n)
    cp_event_i |=> stat_q[CP_BIT]); // R9

  AST_CP_QUIET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    prog_wr_i && !prog_chg_i && !cp_event_i |=> !stat_q[CP_BIT]); // R9

  AST_RESP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_i && req_ready_o |=> resp_valid_o); // R11

  AST_RESP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid_o && !resp_ready_i |=> resp_valid_o && $stable(resp_data_o)); // R12

  AST_STALL_READY: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid_o && !resp_ready_i |-> !req_ready_o); // R12
endmodule

bind chan_flag_regs cfr_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cond_i(cond_i), .cp_event_i(cp_event_i),
  .prog_wr_i(prog_wr_i), .prog_chg_i(prog_chg_i), .wr_en_i(wr_en_i),
  .wr_sel_i(wr_sel_i), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
  .req_sel_i(req_sel_i), .resp_valid_o(resp_valid_o), .resp_ready_i(resp_ready_i),
  .resp_data_o(resp_data_o), .srq_o(srq_o), .stat_q(stat_q), .acc_q(acc_q),
  .mask_q(mask_q), .fault_q(fault_q), .srq_en_q(srq_en_q)
);

// File: tb/tb_chan_flag_regs.sv
`timescale 1ns/100ps
module tb_chan_flag_regs;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] cond_i = '0;
  logic       cp_event_i = 1'b0, prog_wr_i = 1'b0, prog_chg_i = 1'b0;
  logic       wr_en_i = 1'b0, wr_sel_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic       req_valid_i = 1'b0;
  logic [1:0] req_sel_i = '0;
  logic       resp_ready_i = 1'b1;
  logic       req_ready_o, resp_valid_o, srq_o;
  logic [7:0] resp_data_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  string cur_tag = "R11";

  // reference state built from the requirements
  logic [7:0] m_stat = '0, m_acc = '0, m_mask = '0, m_fault = '0;
  logic       m_en = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  chan_flag_regs dut (.*);

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // model + monitor, using the values held since the last falling edge
  always @(posedge clk) begin : model
    logic       cp_n;
    logic [7:0] s_n, pick;
    logic       fire;
    if (resp_valid_o && resp_ready_i) begin
      if (exp_q.size() == 0) chk("R11 spurious", resp_data_o, 8'h00);
      else chk(tag_q.pop_front(), resp_data_o, exp_q.pop_front());
    end
    if (!rst_n) begin
      m_stat <= '0; m_acc <= '0; m_mask <= '0; m_fault <= '0; m_en <= 1'b0;
    end else begin
      fire = req_valid_i && req_ready_o;
      cp_n = m_stat[7];
      if (cp_event_i) cp_n = 1'b1;
      else if (prog_wr_i && !prog_chg_i) cp_n = 1'b0;
      s_n = {cp_n, cond_i};
      case (req_sel_i)
        2'd0: pick = m_stat;
        2'd1: pick = m_acc;
        2'd2: pick = m_mask;
        default: pick = m_fault;
      endcase
      if (fire) begin exp_q.push_back(pick); tag_q.push_back(cur_tag); end
      m_acc   <= (fire && req_sel_i == 2'd1) ? s_n : (m_acc | s_n);
      m_fault <= (fire && req_sel_i == 2'd3) ? 8'h00 : (m_fault | (m_stat & m_mask));
      if (wr_en_i && !wr_sel_i) m_mask <= wr_data_i;
      if (wr_en_i && wr_sel_i)  m_en <= wr_data_i[0];
      m_stat <= s_n;
    end
  end

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic rd(logic [1:0] sel, string tag);
    cur_tag = tag; req_sel_i = sel; req_valid_i = 1'b1;
    tick();
    req_valid_i = 1'b0;
  endtask

  task automatic wr(logic sel, logic [7:0] d);
    wr_sel_i = sel; wr_data_i = d; wr_en_i = 1'b1;
    tick();
    wr_en_i = 1'b0;
  endtask

  task automatic chk_srq(string tag);
    chk(tag, {7'd0, srq_o}, {7'd0, m_en & (|m_fault)});
  endtask

  initial begin
    tick(3); rst_n = 1'b1; tick();
    // R10 reset state
    chk("R10 srq", {7'd0, srq_o}, 8'h00);
    chk("R10 req_ready", {7'd0, req_ready_o}, 8'h01);
    chk("R10 resp_valid", {7'd0, resp_valid_o}, 8'h00);
    rd(0, "R10 status"); rd(1, "R10 accum"); rd(2, "R10 mask"); rd(3, "R10 fault");
    // R1 constant voltage, then an over-voltage blip
    cond_i = 7'h01; tick(2); rd(0, "R1 status cv");
    cond_i = 7'h09; tick(); cond_i = 7'h01; tick(2);
    rd(1, "R4 accum ov+cv");
    chk("R4 example value", m_acc, 8'h01);
    rd(1, "R4 accum reloaded");
    // R3 several conditions accumulate
    cond_i = 7'h20; tick(); cond_i = 7'h44; tick(); cond_i = 7'h01; tick();
    rd(1, "R3 accum gather");
    // R4 condition arriving with the read
    cond_i = 7'h10; rd(1, "R4 same-cycle read"); cond_i = 7'h01; tick();
    rd(1, "R4 same-cycle kept");
    // R2 / R5 writes
    wr(0, 8'h08); rd(2, "R5 mask written"); rd(0, "R2 status unchanged");
    tick(4); rd(2, "R5 mask held");
    // R6 fault sticky
    cond_i = 7'h09; tick(); cond_i = 7'h01; tick(3);
    chk_srq("R8 disabled");
    rd(3, "R6 fault sticky");
    cond_i = 7'h09; tick(); cond_i = 7'h01; tick(2);
    wr(1, 8'h01); tick();
    chk_srq("R8 enabled");
    chk("R8 srq high", {7'd0, srq_o}, 8'h01);
    // R7 clear on read, with condition still held
    rd(3, "R7 fault read"); tick();
    chk_srq("R8 after clear");
    cond_i = 7'h09; tick(2);
    rd(3, "R7 relatch 1"); rd(3, "R7 gap"); tick(); rd(3, "R7 relatch 2");
    cond_i = 7'h01; tick(2); rd(3, "R7 drain"); tick();
    // R9 coupled flag
    cp_event_i = 1'b1; tick(); cp_event_i = 1'b0; tick();
    rd(0, "R9 cp set");
    prog_wr_i = 1'b1; prog_chg_i = 1'b1; tick(); prog_wr_i = 1'b0; prog_chg_i = 1'b0; tick();
    rd(0, "R9 cp kept on change");
    prog_wr_i = 1'b1; tick(); prog_wr_i = 1'b0; tick();
    rd(0, "R9 cp quiet clear");
    prog_wr_i = 1'b1; cp_event_i = 1'b1; tick(); prog_wr_i = 1'b0; cp_event_i = 1'b0; tick();
    rd(0, "R9 set wins");
    // R12 back-pressure
    resp_ready_i = 1'b0;
    rd(1, "R12 stalled first");
    cond_i = 7'h02; req_sel_i = 2'd3; req_valid_i = 1'b1; cur_tag = "R12 pending";
    tick(3);
    chk("R12 ready low", {7'd0, req_ready_o}, 8'h00);
    chk("R12 valid held", {7'd0, resp_valid_o}, 8'h01);
    resp_ready_i = 1'b1; tick(); req_valid_i = 1'b0; cond_i = 7'h01; tick(3);
    rd(1, "R12 no early reload");
    tick(3);
    chk("R11 queue drained", 8'(exp_q.size()), 8'h00);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule